// File: doc/BRIEF.md
# SPI Flash Fast-Read Target

This block behaves like the read path of a serial NOR flash that answers only the fast-read command. It oversamples SCK, chip-enable and SI with the system clock. While chip-enable is low it collects a command byte, a 24-bit address and one dummy byte. It then streams bytes from an internal array on SO, one after another, until chip-enable goes high.

A 20-bit read pointer advances after every byte and wraps from the top of a 1 MB space back to zero. The array holds 2^MEM_AW bytes and is indexed by the low MEM_AW bits of that pointer, so a small array repeats across the 1 MB space. SO is a value plus an output-enable; a low enable stands for high impedance. A synchronous backdoor write port lets a testbench load the array before any transaction.

Top module: `spi_fr_target`

## Requirements
- R1: The target accepts the command byte 0x0B, sampled MSB first on rising SCK in the first 8 clocks of a transaction.
- R2: The next 24 SCK clocks carry the address, most significant bit first. The first data byte comes from the array entry at the low 20 address bits, taken modulo the array depth.
- R3: The 8 clocks after the address are a dummy byte whose value has no effect on the data returned.
- R4: Data starts at the first falling SCK after the dummy byte. Each byte is driven MSB first, and SO changes only on falling SCK.
- R5: The read pointer increments after every output byte, so consecutive bytes come from consecutive addresses for as long as chip-enable stays low.
- R6: After the byte at address 0xFFFFF, the next byte comes from address 0x00000.
- R7: The output enable stays low during the command, address and dummy phases.
- R8: A rising edge on chip-enable ends the stream and drops the output enable.
- R9: Transactions work with SCK idle low (mode 0) and with SCK idle high (mode 3). In mode 3 the leading falling edge is ignored.
- R10: If the command byte is anything other than 0x0B, the output enable stays low until chip-enable rises.
- R11: Address bits 23 down to 20 have no effect on which byte is returned.
- R12: A transaction cut off mid-byte leaves no trace, so the next transaction decodes its command from its own first bit.
- R13: A backdoor write stores its byte at the given array index, and later reads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip enable |
| si_i | input | 1 | Serial data into the target |
| so_o | output | 1 | Serial data out of the target |
| so_oe_o | output | 1 | Output enable for so_o; low means high impedance |
| bd_we_i | input | 1 | Backdoor write strobe |
| bd_addr_i | input | MEM_AW | Backdoor write index |
| bd_data_i | input | 8 | Backdoor write byte |

## Verification
The assertions rely on two conditions. Each SCK level must last several system clocks, so that every serial edge shows up as one clean pulse after synchronization. Chip-enable must change only while SCK sits at its idle level. The bench keeps SCK at six system clocks per half period and moves chip-enable only with SCK parked. Random transactions vary the start address, the upper address nibble, the dummy value, the length and the SCK mode. Directed cases cover the address wrap, a rejected command and a transfer aborted in the middle of the address.

// File: rtl/spi_fr_pkg.sv
package spi_fr_pkg;
  localparam logic [7:0] OPC_FAST_READ = 8'h0B;
  localparam int unsigned PTR_AW = 20;
  localparam int unsigned CNT_W  = 6;
  localparam logic [CNT_W-1:0] LAST_OPC  = 6'd7;
  localparam logic [CNT_W-1:0] LAST_ADDR = 6'd31;
  localparam logic [CNT_W-1:0] LAST_DUMY = 6'd39;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_DUMY, PH_DATA, PH_IGN
  } phase_e;
endpackage

// File: rtl/spi_fr_sync.sv
module spi_fr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic csn_o,
  output logic si_o
);
  logic [STAGES:0]   sck_r;
  logic [STAGES-1:0] csn_r, si_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_r <= '0;
      csn_r <= '1;
      si_r  <= '0;
    end else begin
      sck_r <= {sck_r[STAGES-1:0], sck_i};
      csn_r <= {csn_r[STAGES-2:0], csn_i};
      si_r  <= {si_r[STAGES-2:0], si_i};
    end
  end

  assign sck_rise_o = sck_r[STAGES-1] & ~sck_r[STAGES];
  assign sck_fall_o = ~sck_r[STAGES-1] & sck_r[STAGES];
  assign csn_o      = csn_r[STAGES-1];
  assign si_o       = si_r[STAGES-1];
endmodule

// File: rtl/spi_fr_mem.sv
module spi_fr_mem #(
  parameter int unsigned MEM_AW = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [MEM_AW-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [MEM_AW-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned DEPTH = 1 << MEM_AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_fr_ctrl.sv
module spi_fr_ctrl
  import spi_fr_pkg::*;
#(
  parameter int unsigned MEM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              csn_i,
  input  logic              si_i,
  input  logic [7:0]        rd_data_i,
  output logic [MEM_AW-1:0] rd_addr_o,
  output logic              so_o,
  output logic              so_oe_o,
  output phase_e            phase_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [PTR_AW-1:0] ptr_o,
  output logic              byte_load_o
);
  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [18:0]        rx_q;
  logic [PTR_AW-1:0]  ptr_q;
  logic [7:0]         tx_q;
  logic [2:0]         obit_q;
  logic               so_q, oe_q;
  logic               shift_in, shift_out;

  assign shift_in    = !csn_i && sck_rise_i &&
                       (phase_q == PH_CMD || phase_q == PH_ADDR || phase_q == PH_DUMY);
  assign shift_out   = !csn_i && sck_fall_i && phase_q == PH_DATA;
  assign byte_load_o = shift_out && obit_q == 3'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      rx_q    <= '0;
      ptr_q   <= '0;
      tx_q    <= '0;
      obit_q  <= '0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else if (csn_i) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      obit_q  <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (shift_in) begin
        rx_q  <= {rx_q[17:0], si_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_OPC)
          phase_q <= ({rx_q[6:0], si_i} == OPC_FAST_READ) ? PH_ADDR : PH_IGN;
        if (cnt_q == LAST_ADDR) begin
          phase_q <= PH_DUMY;
          ptr_q   <= {rx_q[18:0], si_i};  // A23..A20 dropped
        end
        if (cnt_q == LAST_DUMY) phase_q <= PH_DATA;
      end
      if (shift_out) begin
        oe_q   <= 1'b1;
        obit_q <= obit_q + 1'b1;
        if (obit_q == 3'd0) begin
          so_q  <= rd_data_i[7];
          tx_q  <= {rd_data_i[6:0], 1'b0};
          ptr_q <= ptr_q + 1'b1;
        end else begin
          so_q <= tx_q[7];
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  assign rd_addr_o = ptr_q[MEM_AW-1:0];
  assign so_o      = so_q;
  assign so_oe_o   = oe_q;
  assign phase_o   = phase_q;
  assign bit_cnt_o = cnt_q;
  assign ptr_o     = ptr_q;
endmodule

// File: rtl/spi_fr_target.sv
module spi_fr_target
  import spi_fr_pkg::*;
#(
  parameter int unsigned MEM_AW = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic              bd_we_i,
  input  logic [MEM_AW-1:0] bd_addr_i,
  input  logic [7:0]        bd_data_i
);
  logic              sck_rise, sck_fall, csn_s, si_s, byte_load;
  logic [7:0]        rd_data;
  logic [MEM_AW-1:0] rd_addr;
  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [PTR_AW-1:0] ptr;

  spi_fr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .csn_i, .si_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .csn_o(csn_s), .si_o(si_s)
  );

  spi_fr_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk_i, .we_i(bd_we_i), .waddr_i(bd_addr_i), .wdata_i(bd_data_i),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  spi_fr_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
    .clk_i, .rst_ni, .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .csn_i(csn_s), .si_i(si_s), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .so_o, .so_oe_o, .phase_o(phase), .bit_cnt_o(bit_cnt), .ptr_o(ptr),
    .byte_load_o(byte_load)
  );
endmodule

// File: rtl/spi_fr_target_chk.sv
module spi_fr_target_chk
  import spi_fr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_s,
  input logic              so_oe_o,
  input phase_e            phase,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [PTR_AW-1:0] ptr,
  input logic              byte_load
);
  AST_OE_DATA_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> phase == PH_DATA); // R7
  AST_CE_RISE_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |=> !so_oe_o); // R8
  AST_PTR_STEP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_load |=> ptr == $past(ptr) + 1'b1); // R5 R6
  AST_BAD_OPC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_IGN |-> !so_oe_o); // R10
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= 6'd40); // R3
  AST_ABORT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |=> (phase == PH_CMD && bit_cnt == '0)); // R12
endmodule

bind spi_fr_target spi_fr_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_s(csn_s), .so_oe_o(so_oe_o),
  .phase(phase), .bit_cnt(bit_cnt), .ptr(ptr), .byte_load(byte_load)
);

// File: tb/spi_fr_target_test.sv
module spi_fr_target_test;
  localparam int MEM_AW = 10;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int HALF   = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, csn = 1'b1, si = 1'b0;
  logic so, so_oe;
  logic bd_we = 1'b0;
  logic [MEM_AW-1:0] bd_addr = '0;
  logic [7:0] bd_data = '0;
  logic [7:0] model [DEPTH];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_fr_target #(.MEM_AW(MEM_AW)) uut (
    .clk_i(clk), .rst_ni, .sck_i(sck), .csn_i(csn), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .bd_we_i(bd_we), .bd_addr_i(bd_addr),
    .bd_data_i(bd_data)
  );

  function automatic logic [7:0] exp_byte(input logic [23:0] a, input int k);
    logic [19:0] p = a[19:0] + 20'(k);
    return model[p[MEM_AW-1:0]];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bd_write(input int idx, input logic [7:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = MEM_AW'(idx); bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
    model[idx] = d;
  endtask

  // one SCK period: fall, settle, sample, rise
  task automatic sbit(input logic b, output logic o, output logic oe);
    sck = 1'b0; si = b;
    wait_clk(HALF);
    o = so; oe = so_oe;
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  // nbits_stop > 0 aborts after that many header bits
  task automatic xfer(input logic [7:0] opc, input logic [23:0] a, input int nbytes,
                      input bit mode3, input string req, input int nbits_stop);
    logic [39:0] hdr = {opc, a, 8'($urandom)};
    logic o, oe;
    logic [7:0] got;
    int hdr_oe = 0;
    int nh = (nbits_stop > 0) ? nbits_stop : 40;
    sck = mode3;
    wait_clk(HALF);
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nh; i++) begin
      sbit(hdr[39-i], o, oe);
      hdr_oe += int'(oe);
    end
    check({req, " R7 oe low in header"}, hdr_oe, 0);
    for (int k = 0; k < nbytes && nbits_stop == 0; k++) begin
      int oe_cnt = 0;
      for (int b = 0; b < 8; b++) begin
        sbit(1'b0, o, oe);
        got[7-b] = o;
        oe_cnt += int'(oe);
      end
      if (opc == 8'h0B) begin
        check({req, " R4 data byte"}, got, exp_byte(a, k));
        check({req, " R4 oe during data"}, oe_cnt, 8);
      end else begin
        check({req, " R10 oe low after bad opcode"}, oe_cnt, 0);
      end
    end
    if (!mode3) begin sck = 1'b0; wait_clk(HALF); end
    csn = 1'b1;
    wait_clk(HALF);
    check({req, " R8 oe low after CE_n rise"}, so_oe, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'($urandom);
    wait_clk(3);
    rst_ni = 1'b1;
    for (int i = 0; i < DEPTH; i++) bd_write(i, model[i]);
    wait_clk(4);
    check("R8 reset oe", so_oe, 1'b0);

    xfer(8'h0B, 24'h000010, 4, 1'b0, "R1 R2 R5 mode0", 0);
    xfer(8'h0B, 24'h000123, 3, 1'b1, "R9 mode3", 0);
    xfer(8'h0B, 24'h0FFFFE, 4, 1'b0, "R6 wrap", 0);
    xfer(8'h0B, 24'hA00321, 2, 1'b1, "R11 high nibble", 0);
    xfer(8'h3B, 24'h000010, 2, 1'b0, "R10 bad opcode", 0);
    xfer(8'h0B, 24'h000040, 0, 1'b0, "R12 abort", 13);
    xfer(8'h0B, 24'h000040, 2, 1'b0, "R12 after abort", 0);
    bd_write(40, 8'h5A);
    xfer(8'h0B, 24'h000028, 1, 1'b1, "R13 backdoor", 0);
    for (int t = 0; t < 14; t++) begin
      logic [23:0] a = 24'($urandom);
      xfer(8'h0B, a, 1 + int'($urandom % 4), 1'($urandom), "R3 R5 random", 0);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule